// File: doc/BRIEF.md
# Glitch-Free Selectable Card Clock Divider

This block produces the clock that drives a smart card contact from a fast system clock. The reference frequency is defined as half of `clk`, so a plain toggle on every `clk` edge gives that reference. A two-bit select input picks one of four output frequencies: the reference itself, half of it, a quarter of it or an eighth of it. The output is a registered signal in the `clk` domain with a 50% duty cycle in every mode.

One free-running counter, started at reset, produces all four ratios. Because of that, every ratio keeps a fixed phase with the others. A new ratio is taken over only at the point where all the divided clocks fall together. The last pulse of the old ratio and the first pulse of the new one therefore both keep full width, and no runt pulse appears at the switch.

A run-enable input from the activation sequencer starts and stops the clock. Both actions happen only at a falling boundary of the selected clock. A stopped clock rests low, and no truncated first or last pulse is produced.

Top module: `card_clk_divider`

## Requirements
- R1: While `rst` is high, and after it until a start has taken effect, `card_clk` is 0. Whenever the gate is stopped, `card_clk` is 0.
- R2: `ratio_sel` encoding. 2'b00 gives a period of 16 `clk` cycles (reference/8). 2'b01 gives 8 cycles (reference/4). 2'b11 gives 4 cycles (reference/2). 2'b10 gives 2 cycles (reference, pass-through).
- R3: In every mode, the high and low phases of `card_clk` each last exactly half of the selected period. Edges occur only where the number of `clk` edges since reset is a multiple of that half period.
- R4: A ratio change takes effect only where the number of `clk` edges since reset is a multiple of 16, the point where all ratios fall together. The pulse before the switch and the pulse after it both keep full width.
- R5: `ratio_sel` passes through one register stage. The value applied at a switch point is the one present at the `clk` edge just before it. A value held for a time in which no switch point sees it has no effect on `card_clk`.
- R6: A rising `run_en` (after one register stage) starts the clock only at a falling boundary of the selected clock. The first high pulse has full width.
- R7: A falling `run_en` (after one register stage) stops the clock only at a falling boundary of the selected clock. The pulse in progress completes, and `card_clk` then stays 0.
- R8: While running with shift k (k = 3, 2, 1, 0 for codes 00, 01, 11, 10), after the t-th `clk` edge since reset `card_clk` equals bit k of t.
- R9: Ratio changes keep being applied while the clock is stopped, so the next start runs at the most recently selected ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the reference frequency |
| rst | input | 1 | Synchronous active-high reset |
| ratio_sel | input | SEL_W (2) | Division ratio select, encoded as in R2 |
| run_en | input | 1 | Gate request from the sequencer, 1 = run |
| card_clk | output | 1 | Registered card clock |

## Verification
The bench builds the block with its default `SEL_W = 2`, which gives four ratios and a 16-cycle common boundary. That configuration is small enough to sweep exhaustively. The bench visits every ordered pair of ratio codes, each with a switch request at a different offset inside the 16-cycle frame. It also starts and stops the gate at many offsets in every mode. An arithmetic model based on the count of `clk` edges since reset predicts `card_clk` on every cycle. Separate width measurements confirm the period and duty cycle of each code.

// File: rtl/ckdv_pkg.sv
package ckdv_pkg;

  typedef enum logic {
    CK_STOPPED = 1'b0,
    CK_RUNNING = 1'b1
  } gate_e;

  // Prefix XOR: converts a Gray-coded select value to binary.
  function automatic int unsigned gray_to_bin(input int unsigned g);
    int unsigned b;
    b = g;
    for (int s = 1; s < 32; s = s * 2) begin
      b = b ^ (b >> s);
    end
    return b;
  endfunction

endpackage

// File: rtl/ckdv_counter.sv
module ckdv_counter #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_d,
  output logic [CW-1:0] phase_edge
);

  // Bit k of the count is the clock that divides by 2^k relative to the reference.
  assign cnt_d = cnt_q + CW'(1);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  // phase_edge[k]: the next edge is a falling boundary of divided clock k.
  for (genvar k = 0; k < CW; k++) begin : g_edge
    assign phase_edge[k] = &cnt_q[k:0];
  end

endmodule

// File: rtl/ckdv_ratio_sel.sv
module ckdv_ratio_sel
  import ckdv_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel_pin,
  input  logic             wrap,
  output logic [SEL_W-1:0] act_q,
  output logic [SEL_W-1:0] act_d
);

  localparam int NR = 2 ** SEL_W;

  logic [SEL_W-1:0] sel_q;
  logic [SEL_W-1:0] shift_req;

  // The select code is Gray-ordered from the slowest ratio to the fastest.
  always_comb begin
    shift_req = SEL_W'(NR - 1 - int'(gray_to_bin(int'(sel_q))));
  end

  assign act_d = wrap ? shift_req : act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      act_q <= SEL_W'(NR - 1);
    end else begin
      sel_q <= sel_pin;
      act_q <= act_d;
    end
  end

  // R4: the active ratio moves only when all divided clocks fall together.
  assert_switch_on_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (act_q != $past(act_q)) |-> $past(wrap));

endmodule

// File: rtl/ckdv_gate.sv
module ckdv_gate
  import ckdv_pkg::*;
#(
  parameter int SEL_W = 2,
  parameter int CW    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_pin,
  input  logic [CW-1:0]    phase_edge,
  input  logic [SEL_W-1:0] act_q,
  output gate_e            run_q,
  output gate_e            run_d
);

  logic  en_q;
  logic  at_low_start;
  gate_e req;

  assign at_low_start = phase_edge[act_q];
  assign req          = en_q ? CK_RUNNING : CK_STOPPED;
  assign run_d        = at_low_start ? req : run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      run_q <= CK_STOPPED;
    end else begin
      en_q  <= run_pin;
      run_q <= run_d;
    end
  end

  // R6/R7: the gate changes state only at a falling boundary of the selected clock.
  assert_gate_on_low_R6: assert property (@(posedge clk) disable iff (rst)
    (run_q != $past(run_q)) |-> $past(at_low_start));

endmodule

// File: rtl/card_clk_divider.sv
module card_clk_divider
  import ckdv_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] ratio_sel,
  input  logic             run_en,
  output logic             card_clk
);

  localparam int NR = 2 ** SEL_W;
  localparam int CW = NR;

  logic [CW-1:0]    cnt_q;
  logic [CW-1:0]    cnt_d;
  logic [CW-1:0]    phase_edge;
  logic [SEL_W-1:0] act_q;
  logic [SEL_W-1:0] act_d;
  gate_e            run_q;
  gate_e            run_d;

  ckdv_counter #(.CW(CW)) u_counter (
    .clk        (clk),
    .rst        (rst),
    .cnt_q      (cnt_q),
    .cnt_d      (cnt_d),
    .phase_edge (phase_edge)
  );

  ckdv_ratio_sel #(.SEL_W(SEL_W)) u_ratio (
    .clk     (clk),
    .rst     (rst),
    .sel_pin (ratio_sel),
    .wrap    (phase_edge[CW-1]),
    .act_q   (act_q),
    .act_d   (act_d)
  );

  ckdv_gate #(.SEL_W(SEL_W), .CW(CW)) u_gate (
    .clk        (clk),
    .rst        (rst),
    .run_pin    (run_en),
    .phase_edge (phase_edge),
    .act_q      (act_q),
    .run_q      (run_q),
    .run_d      (run_d)
  );

  // The output register sees the next counter, ratio and gate state,
  // so card_clk lines up with the registered state.
  always_ff @(posedge clk) begin
    if (rst) card_clk <= 1'b0;
    else     card_clk <= (run_d == CK_RUNNING) && cnt_d[act_d];
  end

  logic [CW-1:0] half_mask;
  assign half_mask = (CW'(1) << act_q) - CW'(1);

  // R1: a stopped gate never lets a high level through.
  assert_stopped_low_R1: assert property (@(posedge clk) disable iff (rst)
    card_clk |-> (run_q == CK_RUNNING));

  // R3: every output edge falls on a half-period boundary of the active ratio.
  assert_edge_aligned_R3: assert property (@(posedge clk) disable iff (rst)
    (card_clk != $past(card_clk)) |-> ((cnt_q & half_mask) == '0));

endmodule

// File: tb/test_card_clk_divider.sv
module test_card_clk_divider;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] ratio_sel = 2'b00;
  logic       run_en = 1'b0;
  logic       card_clk;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done   = 0;
  bit chk_on = 0;
  string cur_req = "R1";

  card_clk_divider #(.SEL_W(2)) i_card_clk_divider (
    .clk       (clk),
    .rst       (rst),
    .ratio_sel (ratio_sel),
    .run_en    (run_en),
    .card_clk  (card_clk)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Shift k from the code table in R2: the period is 2^(k+1) clk cycles.
  function automatic int code_shift(input logic [1:0] c);
    case (c)
      2'b00:   return 3;
      2'b01:   return 2;
      2'b11:   return 1;
      default: return 0;
    endcase
  endfunction

  // Arithmetic expectation built from t = clk edges since reset (R4..R9).
  int   m_t, m_act;
  bit   m_run, m_out;
  logic [1:0] m_sel_prev;
  bit   m_en_prev;

  always @(posedge clk) begin
    if (rst) begin
      m_t = 0; m_act = 3; m_run = 0; m_out = 0;
      m_sel_prev = 2'b00; m_en_prev = 0;
    end else begin
      int  t_new;
      bit  bound;
      t_new = m_t + 1;
      bound = (t_new % (2 << m_act)) == 0;
      if (bound) m_run = m_en_prev;
      if (t_new % 16 == 0) m_act = code_shift(m_sel_prev);
      m_out = m_run && (((t_new >> m_act) & 1) == 1);
      m_t = t_new;
      m_sel_prev = ratio_sel;
      m_en_prev  = run_en;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at t=%0d", req, act, exp, m_t);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      if (rst) check("R1 reset", int'(card_clk), 0);
      else if (chk_on) check(cur_req, int'(card_clk), int'(m_out));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog (all requirements) actual=%0d expected<%0d", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R2/R3: measure one full high phase and the following low phase at the port.
  task automatic measure(input logic [1:0] code);
    int hi, lo, half;
    half = 1 << code_shift(code);
    while (card_clk !== 1'b0) @(negedge clk);
    while (card_clk !== 1'b1) @(negedge clk);
    hi = 0;
    while (card_clk === 1'b1) begin hi++; @(negedge clk); end
    lo = 0;
    while (card_clk === 1'b0) begin lo++; @(negedge clk); end
    check("R2 period", hi + lo, 2 * half);
    check("R3 high width", hi, half);
    check("R3 low width", lo, half);
  endtask

  initial begin
    tick(4);
    rst = 1'b0;
    chk_on = 1;

    // R1 and R9: stopped clock stays low while the ratio changes underneath.
    cur_req = "R1/R9 stopped";
    ratio_sel = 2'b10; tick(20);
    ratio_sel = 2'b01; tick(20);

    // R6 and R8: start and run at the last selected ratio.
    cur_req = "R6/R8 start";
    run_en = 1'b1; tick(40);

    // R2/R3: period and duty for every code.
    for (int c = 0; c < 4; c++) begin
      cur_req = "R2/R3 steady";
      ratio_sel = 2'(c); tick(40);
      measure(2'(c));
    end

    // R4: every ordered pair of codes, requested at a varying frame offset.
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        cur_req = "R4 switch";
        ratio_sel = 2'(a); tick(36);
        tick((a * 4 + b) * 5 % 16);
        ratio_sel = 2'(b); tick(36);
      end
    end

    // R5: short select pulses of 1..3 cycles at every frame offset.
    for (int off = 0; off < 16; off++) begin
      cur_req = "R5 short select";
      ratio_sel = 2'b11; tick(34 + off);
      ratio_sel = 2'b00; tick(1 + off % 3);
      ratio_sel = 2'b11; tick(20);
    end

    // R6/R7: start and stop at many offsets in every mode.
    for (int c = 0; c < 4; c++) begin
      for (int off = 0; off < 16; off += 3) begin
        cur_req = "R6/R7 gating";
        ratio_sel = 2'(c);
        run_en = 1'b0; tick(36 + off);
        run_en = 1'b1; tick(30 + off);
        run_en = 1'b0; tick(36);
      end
    end

    // R9: change the ratio while stopped, then restart.
    cur_req = "R9 retarget while stopped";
    ratio_sel = 2'b00; run_en = 1'b1; tick(40);
    run_en = 1'b0; tick(40);
    ratio_sel = 2'b10; tick(40);
    run_en = 1'b1; tick(10);
    measure(2'b10);

    // R8: long steady run at the slowest ratio.
    cur_req = "R8 phase";
    ratio_sel = 2'b00; tick(80);

    chk_on = 0;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule